// File: doc/BRIEF.md
# PHY Cold Reset Sequencer

This block produces the power-up reset waveform for a memory PHY. Three outputs are driven: an active-low reset for the PHY's register bus, an active-low reset for the PHY core, and an active-high power-good level. A one-cycle start request sets off a fixed run of three timed phases. First both resets are let go with power-good low. Next both resets are pulled in together. Then power-good is raised while the resets stay pulled in. When the last dwell expires, both resets are let go together, a done flag pulses and the block goes back to idle.

Each phase lasts the same number of clock cycles. That count is taken from the dwell input at the moment the start request is accepted. A system clock of 100 MHz with a dwell near 1,000,000 gives the roughly 10 ms per phase that a real PHY needs. A testbench can pass a small dwell. The block only handles reset timing. PHY configuration, training and clock selection belong to other logic.

All pins are plain control and status levels. Nothing streams through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `phy_rst_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, the outputs are bus_rst_n_o=1, core_rst_n_o=0, pwr_good_o=0, busy_o=0 and done_o=0.
- R2: If start_i is high at a clock edge while busy_o is low, the outputs from the next cycle on are bus_rst_n_o=1, core_rst_n_o=1, pwr_good_o=0, with busy_o=1.
- R3: The phase started in R2 lasts exactly D cycles. After it come D cycles of bus_rst_n_o=0, core_rst_n_o=0, pwr_good_o=0.
- R4: The phase in R3 is followed by D cycles of bus_rst_n_o=0, core_rst_n_o=0, pwr_good_o=1. Power-good rises only while both resets are low.
- R5: Exactly 3*D cycles after busy_o rises, the outputs become bus_rst_n_o=1, core_rst_n_o=1, pwr_good_o=1, with done_o=1 and busy_o=0 in that same cycle.
- R6: While busy_o is high, bus_rst_n_o and core_rst_n_o are always equal.
- R7: start_i has no effect while busy_o is high. busy_o falls only in the cycle where done_o rises.
- R8: D is the value of dwell_i at the edge where start is accepted. Later changes to dwell_i do not change the current run.
- R9: A dwell_i of 0 is handled as D=1.
- R10: After done_o, the three levels hold at 1,1,1 until a new start is accepted. A start that is high in the done_o cycle is accepted.
- R11: done_o is high for exactly one cycle per completed run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to run the sequence |
| dwell_i | input | CNT_W | Cycles per phase, captured at start |
| bus_rst_n_o | output | 1 | Register-bus reset to the PHY, active low |
| core_rst_n_o | output | 1 | Core reset to the PHY, active low |
| pwr_good_o | output | 1 | Power-good to the PHY, active high |
| busy_o | output | 1 | High while the sequence is running |
| done_o | output | 1 | One-cycle pulse when the final levels are applied |

## Verification
Two events can land in the same cycle: the completion pulse, and the acceptance of a new start. The bench holds start_i high across the end of a run, so a request is present in exactly the cycle where done_o is high. That request must begin a fresh run on the next cycle, with no idle gap, and the first phase must drop power-good again. The bench also sends start pulses and changes dwell_i in the middle of a run, which would collide with the phase timer, and then checks that the run length and the phase edges still match the dwell captured at start.

// File: rtl/phy_rst_seq_pkg.sv
package phy_rst_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_OPEN  = 2'd1,
    PH_CLAMP = 2'd2,
    PH_POWER = 2'd3
  } seq_phase_e;

  typedef struct packed {
    logic bus_n;
    logic core_n;
    logic pgood;
  } rst_lvl_t;

  localparam rst_lvl_t LVL_RESET = '{bus_n: 1'b1, core_n: 1'b0, pgood: 1'b0};
  localparam rst_lvl_t LVL_FINAL = '{bus_n: 1'b1, core_n: 1'b1, pgood: 1'b1};

  function automatic rst_lvl_t phase_levels(seq_phase_e ph);
    rst_lvl_t l;
    case (ph)
      PH_OPEN:  l = '{bus_n: 1'b1, core_n: 1'b1, pgood: 1'b0};
      PH_CLAMP: l = '{bus_n: 1'b0, core_n: 1'b0, pgood: 1'b0};
      PH_POWER: l = '{bus_n: 1'b0, core_n: 1'b0, pgood: 1'b1};
      default:  l = LVL_FINAL;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/phy_rst_dwell_timer.sv
module phy_rst_dwell_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // Counts down from D-1, so each phase lasts D cycles.
  assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/phy_rst_phase_fsm.sv
module phy_rst_phase_fsm
  import phy_rst_seq_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] dwell_i,
  input  logic             expire_i,
  output seq_phase_e       phase_q,
  output seq_phase_e       phase_d,
  output logic             fin_d,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] dwell_eff;
  logic [CNT_W-1:0] dwell_lat_q;
  logic             accept;

  // A zero dwell would make a phase vanish, so it is stretched to one cycle.
  assign dwell_eff = (dwell_i == '0) ? ONE : dwell_i;
  assign accept    = (phase_q == PH_IDLE) && start_i;

  always_comb begin
    phase_d    = phase_q;
    fin_d      = 1'b0;
    load_o     = 1'b0;
    load_val_o = dwell_lat_q - ONE;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d    = PH_OPEN;
          load_o     = 1'b1;
          load_val_o = dwell_eff - ONE;
        end
      end
      PH_OPEN: begin
        if (expire_i) begin
          phase_d = PH_CLAMP;
          load_o  = 1'b1;
        end
      end
      PH_CLAMP: begin
        if (expire_i) begin
          phase_d = PH_POWER;
          load_o  = 1'b1;
        end
      end
      PH_POWER: begin
        if (expire_i) begin
          phase_d = PH_IDLE;
          fin_d   = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      dwell_lat_q <= ONE;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        dwell_lat_q <= dwell_eff;
      end
    end
  end

endmodule

// File: rtl/phy_rst_level_reg.sv
module phy_rst_level_reg
  import phy_rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_phase_e phase_d,
  input  logic       fin_d,
  output rst_lvl_t   lvl_q,
  output logic       done_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= LVL_RESET;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_d;
      if (fin_d) begin
        lvl_q <= LVL_FINAL;
      end else if (phase_d != PH_IDLE) begin
        lvl_q <= phase_levels(phase_d);
      end
    end
  end

endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq
  import phy_rst_seq_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] dwell_i,
  output logic             bus_rst_n_o,
  output logic             core_rst_n_o,
  output logic             pwr_good_o,
  output logic             busy_o,
  output logic             done_o
);

  seq_phase_e       phase_q;
  seq_phase_e       phase_d;
  logic             fin_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expire;
  rst_lvl_t         lvl_q;

  phy_rst_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .dwell_i   (dwell_i),
    .expire_i  (expire),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .fin_d     (fin_d),
    .load_o    (load),
    .load_val_o(load_val)
  );

  phy_rst_dwell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .load_val_i(load_val),
    .expire_o  (expire)
  );

  phy_rst_level_reg u_lvl (
    .clk    (clk),
    .rst    (rst),
    .phase_d(phase_d),
    .fin_d  (fin_d),
    .lvl_q  (lvl_q),
    .done_q (done_o)
  );

  assign bus_rst_n_o  = lvl_q.bus_n;
  assign core_rst_n_o = lvl_q.core_n;
  assign pwr_good_o   = lvl_q.pgood;
  assign busy_o       = (phase_q != PH_IDLE);

endmodule

// File: rtl/phy_rst_seq_chk.sv
module phy_rst_seq_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic bus_rst_n_o,
  input logic core_rst_n_o,
  input logic pwr_good_o,
  input logic busy_o,
  input logic done_o
);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  // R4
  pgood_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_good_o) |-> (!bus_rst_n_o && !core_rst_n_o));

  // R5
  done_levels_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && bus_rst_n_o && core_rst_n_o && pwr_good_o));

  // R6
  reset_pair_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (bus_rst_n_o == core_rst_n_o));

  // R7
  busy_exit_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (busy_o || done_o));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable({bus_rst_n_o, core_rst_n_o, pwr_good_o}));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

bind phy_rst_seq phy_rst_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .bus_rst_n_o (bus_rst_n_o),
  .core_rst_n_o(core_rst_n_o),
  .pwr_good_o  (pwr_good_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/phy_rst_seq_test.sv
`timescale 1ns/1ps
module phy_rst_seq_test;

  localparam int CNT_W = 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] dwell_i = CNT_W'(4);
  logic             bus_rst_n_o, core_rst_n_o, pwr_good_o, busy_o, done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  phy_rst_seq #(.CNT_W(CNT_W)) uut (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .dwell_i     (dwell_i),
    .bus_rst_n_o (bus_rst_n_o),
    .core_rst_n_o(core_rst_n_o),
    .pwr_good_o  (pwr_good_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  // Behavioural reference: phase number, cycles left, captured dwell.
  int m_ph = 0;
  int m_left = 0;
  int m_dw = 1;
  bit m_bus = 1'b1, m_core = 1'b0, m_pg = 1'b0, m_done = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_bus = 1; m_core = 0; m_pg = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_ph == 0) begin
        if (start_i) begin
          m_dw = (dwell_i == 0) ? 1 : int'(dwell_i);
          m_left = m_dw; m_ph = 1;
          m_bus = 1; m_core = 1; m_pg = 0;
        end
      end else begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          if (m_ph == 3) begin
            m_ph = 0; m_done = 1;
            m_bus = 1; m_core = 1; m_pg = 1;
          end else begin
            m_ph = m_ph + 1; m_left = m_dw;
            m_bus = 0; m_core = 0; m_pg = (m_ph == 3);
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Compare every cycle against the model.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      string tag;
      int act, exp;
      act = {bus_rst_n_o, core_rst_n_o, pwr_good_o, busy_o, done_o};
      exp = {m_bus, m_core, m_pg, (m_ph != 0), m_done};
      tag = (m_ph == 1) ? "R2" : (m_ph == 2) ? "R3" : (m_ph == 3) ? "R4" :
            m_done ? "R5" : "R10";
      chk(act == exp, tag, act, exp);
    end
  end

  // Length of each busy stretch, taken when done appears.
  int run_len = 0;
  int last_len = -1;
  always @(negedge clk) begin
    if (rst) run_len = 0;
    else if (busy_o) run_len++;
    else if (done_o) begin last_len = run_len; run_len = 0; end
  end

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({bus_rst_n_o, core_rst_n_o, pwr_good_o, busy_o, done_o} == 5'b10000,
        "R1", {bus_rst_n_o, core_rst_n_o, pwr_good_o, busy_o, done_o}, 5'b10000);
    rst = 1'b0;
    @(negedge clk);
    chk({bus_rst_n_o, core_rst_n_o, pwr_good_o, busy_o, done_o} == 5'b10000,
        "R1", {bus_rst_n_o, core_rst_n_o, pwr_good_o, busy_o, done_o}, 5'b10000);

    // Run with D=4; dwell change and extra starts mid-run (R7, R8).
    dwell_i = CNT_W'(4);
    pulse_start();
    chk(busy_o && bus_rst_n_o && core_rst_n_o && !pwr_good_o, "R2", busy_o, 1);
    dwell_i = CNT_W'(9);
    @(negedge clk);
    pulse_start();
    repeat (3) @(negedge clk);
    pulse_start();
    wait_done();
    @(negedge clk);
    chk(last_len == 12, "R8", last_len, 12);
    chk(!done_o, "R11", done_o, 0);

    // Idle hold after completion (R10).
    repeat (6) @(negedge clk);
    chk({bus_rst_n_o, core_rst_n_o, pwr_good_o} == 3'b111, "R10",
        {bus_rst_n_o, core_rst_n_o, pwr_good_o}, 3'b111);

    // Zero dwell (R9).
    dwell_i = '0;
    pulse_start();
    wait_done();
    @(negedge clk);
    chk(last_len == 3, "R9", last_len, 3);

    // Start held high across the done cycle (R10 back-to-back).
    dwell_i = CNT_W'(2);
    start_i = 1'b1;
    wait_done();
    @(negedge clk);
    chk(busy_o && !pwr_good_o, "R10", busy_o, 1);
    start_i = 1'b0;
    wait_done();
    @(negedge clk);
    chk(last_len == 6, "R5", last_len, 6);

    // D=1 and D=3 runs (R3, R4).
    dwell_i = CNT_W'(1);
    pulse_start();
    wait_done();
    @(negedge clk);
    chk(last_len == 3, "R3", last_len, 3);
    dwell_i = CNT_W'(3);
    pulse_start();
    repeat (3) @(negedge clk);
    chk(!bus_rst_n_o && !core_rst_n_o && !pwr_good_o, "R3", pwr_good_o, 0);
    repeat (3) @(negedge clk);
    chk(!bus_rst_n_o && !core_rst_n_o && pwr_good_o, "R4", pwr_good_o, 1);
    chk(bus_rst_n_o == core_rst_n_o, "R6", bus_rst_n_o, core_rst_n_o);
    wait_done();
    @(negedge clk);
    chk(last_len == 9, "R5", last_len, 9);

    // Reset in the middle of a run returns the idle levels (R1).
    pulse_start();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk({bus_rst_n_o, core_rst_n_o, pwr_good_o, busy_o, done_o} == 5'b10000,
        "R1", {bus_rst_n_o, core_rst_n_o, pwr_good_o, busy_o, done_o}, 5'b10000);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

endmodule